// File: doc/BRIEF.md
# Per-Port Multi-Class Transmit Queue Manager

This block holds the pending transmit jobs of a packet switch. Every job is a frame handle, and each port keeps one queue per traffic class. Each queue is a singly linked list. One next-pointer word per handle lives in a shared link memory. Each queue also keeps a head register, a tail register and a length counter.

A forwarding result arrives as a handle together with a destination port and a class. The block accepts it or drops it in the same cycle. The decision uses the global used-buffer count supplied by the buffer manager and the current length of the target queue. An accepted handle is appended to the tail of its queue. A dropped handle is handed straight back on the release output, so the buffer manager can free it.

A port asks for its next frame when its transmit FIFO has room for one more. The block answers in the same cycle. It picks the highest non-empty class of that port and returns the handle at the head of that class's queue, or it reports that nothing is pending.

Top module: `txq_mgr`

## Requirements
- R1: After reset every queue is empty. A request on any port gets `deq_valid_o` = 0.
- R2: An enqueue is accepted when `buf_used_i` <= GLOBAL_LIMIT (default 48) and the target queue holds fewer than QUEUE_LIMIT (default 8) handles. An accepted handle is appended to the queue at index port*CLASSES + class, and `drop_valid_o` stays 0.
- R3: When `buf_used_i` > GLOBAL_LIMIT, an enqueue is dropped in the same cycle. `drop_valid_o` = 1 and `drop_handle_o` equals the offered handle.
- R4: An enqueue to a queue that already holds QUEUE_LIMIT handles is dropped the same way. The queue contents are unchanged.
- R5: A request returns the head of the highest-numbered non-empty class of the port. Class CLASSES-1 (3) is the highest, and empty classes are skipped. `deq_class_o` gives the chosen class.
- R6: A request for a port whose classes are all empty gets `deq_valid_o` = 0 in that cycle and changes no queue.
- R7: Within one queue, handles are returned in the order they were accepted.
- R8: Dequeuing the only entry of a queue leaves it empty. If an enqueue to the same queue happens in that cycle, the new handle becomes the sole entry. A handle enqueued in a cycle is not visible to a request in the same cycle.
- R9: Traffic on one port or class never alters the contents or order of another queue.
- R10: `drop_valid_o` is 1 only in a cycle with `enq_valid_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enq_valid_i | input | 1 | Forwarding result present this cycle |
| enq_handle_i | input | HW (6) | Frame handle to queue |
| enq_port_i | input | PW (5) | Destination port, below PORTS |
| enq_class_i | input | CW (2) | Transmit class |
| buf_used_i | input | UW (7) | Global used-buffer count from the buffer manager |
| drop_valid_o | output | 1 | Offered handle was dropped this cycle |
| drop_handle_o | output | HW (6) | Handle to release, 0 when not dropping |
| deq_req_i | input | 1 | A port has room for another frame |
| deq_port_i | input | PW (5) | Requesting port |
| deq_valid_o | output | 1 | A handle is returned |
| deq_handle_o | output | HW (6) | Returned handle, 0 when not valid |
| deq_class_o | output | CW (2) | Class the handle came from |

## Verification
On every cycle, the embedded assertions check the following:
- no queue grows past its limit, and no enqueue ever reaches a full queue;
- a drop never appears without an offered handle, and an over-threshold offer is always dropped;
- a returned class is busy and no higher class is;
- an all-empty port never answers valid;
- a single-entry dequeue empties the queue, and a first enqueue becomes the head.

Only the bench's reference model can show the rest:
- FIFO order inside a class;
- the outcome of a same-cycle enqueue and dequeue on one queue;
- the isolation between queues under long mixed traffic;
- the exact boundary of both drop thresholds.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_DEF_PORTS   = 24;
  localparam int unsigned TXQ_DEF_CLASSES = 4;
  localparam int unsigned TXQ_DEF_HANDLES = 64;
  localparam int unsigned TXQ_DEF_QLIMIT  = 8;
  localparam int unsigned TXQ_DEF_GLIMIT  = 48;

  typedef enum logic [1:0] {
    ADM_IDLE        = 2'd0,
    ADM_ACCEPT      = 2'd1,
    ADM_DROP_GLOBAL = 2'd2,
    ADM_DROP_QUEUE  = 2'd3
  } adm_verdict_e;
endpackage

// File: rtl/txq_admit.sv
module txq_admit
  import txq_pkg::*;
#(
  parameter int unsigned QUEUE_LIMIT  = TXQ_DEF_QLIMIT,
  parameter int unsigned GLOBAL_LIMIT = TXQ_DEF_GLIMIT,
  parameter int unsigned LW           = 4,
  parameter int unsigned UW           = 7
) (
  input  logic          enq_valid_i,
  input  logic [LW-1:0] tgt_len_i,
  input  logic [UW-1:0] buf_used_i,
  output adm_verdict_e  verdict_o
);
  localparam logic [UW-1:0] GLIM_V = UW'(GLOBAL_LIMIT);
  localparam logic [LW-1:0] QLIM_V = LW'(QUEUE_LIMIT);

  // Global pressure takes precedence over the per-queue limit
  always_comb begin
    if (!enq_valid_i) begin
      verdict_o = ADM_IDLE;
    end else if (buf_used_i > GLIM_V) begin
      verdict_o = ADM_DROP_GLOBAL;
    end else if (tgt_len_i >= QLIM_V) begin
      verdict_o = ADM_DROP_QUEUE;
    end else begin
      verdict_o = ADM_ACCEPT;
    end
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int unsigned CLASSES = 4,
  parameter int unsigned CW      = 2
) (
  input  logic [CLASSES-1:0] busy_i,
  output logic               valid_o,
  output logic [CW-1:0]      cls_o
);
  // Strict priority: the highest-numbered busy class wins
  always_comb begin
    valid_o = |busy_i;
    cls_o   = '0;
    for (int c = 0; c < int'(CLASSES); c++) begin
      if (busy_i[c]) cls_o = CW'(c);
    end
  end
endmodule

// File: rtl/txq_link_mem.sv
module txq_link_mem #(
  parameter int unsigned HANDLES = 64,
  parameter int unsigned HW      = 6
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [HW-1:0] wr_addr_i,
  input  logic [HW-1:0] wr_data_i,
  input  logic [HW-1:0] rd_addr_i,
  output logic [HW-1:0] rd_data_o
);
  logic [HW-1:0] next_q [HANDLES];

  // A word is only read after its owner has been linked behind, so no reset
  always_ff @(posedge clk) begin
    if (wr_en_i) next_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = next_q[rd_addr_i];
endmodule

// File: rtl/txq_qslot.sv
module txq_qslot #(
  parameter int unsigned HW          = 6,
  parameter int unsigned LW          = 4,
  parameter int unsigned QUEUE_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_i,
  input  logic          deq_i,
  input  logic [HW-1:0] enq_handle_i,
  input  logic [HW-1:0] link_next_i,
  output logic [HW-1:0] head_o,
  output logic [HW-1:0] tail_o,
  output logic [LW-1:0] len_o
);
  logic [HW-1:0] head_q, head_d;
  logic [HW-1:0] tail_q, tail_d;
  logic [LW-1:0] len_q, len_d;
  logic          upd;
  logic          lands_at_head;

  assign upd           = enq_i | deq_i;
  assign lands_at_head = (len_q == '0) || (deq_i && (len_q == LW'(1)));

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    len_d  = len_q;
    if (deq_i) head_d = link_next_i;
    if (enq_i) begin
      tail_d = enq_handle_i;
      if (lands_at_head) head_d = enq_handle_i;
    end
    case ({enq_i, deq_i})
      2'b10:   len_d = len_q + LW'(1);
      2'b01:   len_d = len_q - LW'(1);
      default: len_d = len_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (upd) len_q <= len_d;
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign len_o  = len_q;

  // R4
  qlen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LW'(QUEUE_LIMIT));
  // R4
  no_enq_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_i |-> (len_q < LW'(QUEUE_LIMIT)));
  // R8
  single_deq_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_i && !enq_i && (len_q == LW'(1))) |=> (len_q == '0));
endmodule

// File: rtl/txq_mgr.sv
module txq_mgr
  import txq_pkg::*;
#(
  parameter int unsigned PORTS        = TXQ_DEF_PORTS,
  parameter int unsigned CLASSES      = TXQ_DEF_CLASSES,
  parameter int unsigned HANDLES      = TXQ_DEF_HANDLES,
  parameter int unsigned QUEUE_LIMIT  = TXQ_DEF_QLIMIT,
  parameter int unsigned GLOBAL_LIMIT = TXQ_DEF_GLIMIT,
  localparam int unsigned PW = (PORTS > 1)   ? $clog2(PORTS)   : 1,
  localparam int unsigned CW = (CLASSES > 1) ? $clog2(CLASSES) : 1,
  localparam int unsigned HW = (HANDLES > 1) ? $clog2(HANDLES) : 1,
  localparam int unsigned UW = $clog2(HANDLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid_i,
  input  logic [HW-1:0] enq_handle_i,
  input  logic [PW-1:0] enq_port_i,
  input  logic [CW-1:0] enq_class_i,
  input  logic [UW-1:0] buf_used_i,
  output logic          drop_valid_o,
  output logic [HW-1:0] drop_handle_o,
  input  logic          deq_req_i,
  input  logic [PW-1:0] deq_port_i,
  output logic          deq_valid_o,
  output logic [HW-1:0] deq_handle_o,
  output logic [CW-1:0] deq_class_o
);
  localparam int unsigned NQ = PORTS * CLASSES;
  localparam int unsigned QW = $clog2(NQ + 1);
  localparam int unsigned LW = $clog2(QUEUE_LIMIT + 1);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Queue state views
  logic [NQ-1:0][HW-1:0] head_all;
  logic [NQ-1:0][HW-1:0] tail_all;
  logic [NQ-1:0][LW-1:0] len_all;

  // Admission
  logic [QW-1:0] enq_qidx;
  logic [LW-1:0] tgt_len;
  adm_verdict_e  verdict;
  logic          enq_accept;

  assign enq_qidx = QW'(enq_port_i) * QW'(CLASSES) + QW'(enq_class_i);
  assign tgt_len  = len_all[enq_qidx];

  txq_admit #(
    .QUEUE_LIMIT (QUEUE_LIMIT),
    .GLOBAL_LIMIT(GLOBAL_LIMIT),
    .LW          (LW),
    .UW          (UW)
  ) u_admit (
    .enq_valid_i(enq_valid_i),
    .tgt_len_i  (tgt_len),
    .buf_used_i (buf_used_i),
    .verdict_o  (verdict)
  );

  assign enq_accept    = (verdict == ADM_ACCEPT);
  assign drop_valid_o  = (verdict == ADM_DROP_GLOBAL) || (verdict == ADM_DROP_QUEUE);
  assign drop_handle_o = drop_valid_o ? enq_handle_i : '0;

  // Head-of-line selection
  logic [QW-1:0]      deq_base;
  logic [CLASSES-1:0] port_busy;
  logic               sched_valid;
  logic [CW-1:0]      sched_cls;
  logic [QW-1:0]      deq_qidx;
  logic               deq_fire;

  assign deq_base = QW'(deq_port_i) * QW'(CLASSES);

  for (genvar c = 0; c < int'(CLASSES); c++) begin : g_busy
    assign port_busy[c] = (len_all[deq_base + QW'(c)] != '0);
  end

  txq_sched #(
    .CLASSES(CLASSES),
    .CW     (CW)
  ) u_sched (
    .busy_i (port_busy),
    .valid_o(sched_valid),
    .cls_o  (sched_cls)
  );

  assign deq_qidx     = deq_base + QW'(sched_cls);
  assign deq_fire     = deq_req_i && sched_valid;
  assign deq_valid_o  = deq_fire;
  assign deq_class_o  = deq_fire ? sched_cls : '0;
  assign deq_handle_o = deq_fire ? head_all[deq_qidx] : '0;

  // Link memory: write behind the old tail, read behind the served head
  logic [HW-1:0] link_next;
  logic          link_wr;

  assign link_wr = enq_accept && (tgt_len != '0);

  txq_link_mem #(
    .HANDLES(HANDLES),
    .HW     (HW)
  ) u_link (
    .clk      (clk),
    .wr_en_i  (link_wr),
    .wr_addr_i(tail_all[enq_qidx]),
    .wr_data_i(enq_handle_i),
    .rd_addr_i(head_all[deq_qidx]),
    .rd_data_o(link_next)
  );

  // One slot per (port, class)
  for (genvar q = 0; q < int'(NQ); q++) begin : g_q
    logic enq_here;
    logic deq_here;

    assign enq_here = enq_accept && (enq_qidx == QW'(q));
    assign deq_here = deq_fire && (deq_qidx == QW'(q));

    txq_qslot #(
      .HW         (HW),
      .LW         (LW),
      .QUEUE_LIMIT(QUEUE_LIMIT)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .enq_i       (enq_here),
      .deq_i       (deq_here),
      .enq_handle_i(enq_handle_i),
      .link_next_i (link_next),
      .head_o      (head_all[q]),
      .tail_o      (tail_all[q]),
      .len_o       (len_all[q])
    );
  end

  // R10
  drop_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drop_valid_o |-> enq_valid_i);
  // R3
  global_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enq_valid_i && (buf_used_i > UW'(GLOBAL_LIMIT))) |-> (drop_valid_o && (drop_handle_o == enq_handle_i)));
  // R2
  first_enq_heads_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enq_accept && (tgt_len == '0)) |=> (head_all[$past(enq_qidx)] == $past(enq_handle_i)));
  // R5
  strict_prio_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    deq_valid_o |-> ((port_busy >> deq_class_o) == CLASSES'(1)));
  // R6
  empty_port_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (deq_req_i && (port_busy == '0)) |-> !deq_valid_o);
endmodule

// File: tb/txq_mgr_bench.sv
module txq_mgr_bench;
  localparam int PORTS   = 24;
  localparam int CLASSES = 4;
  localparam int HANDLES = 64;
  localparam int QLIM    = 8;
  localparam int GLIM    = 48;
  localparam int NQ      = PORTS * CLASSES;

  logic       clk;
  logic       rst_n;
  logic       enq_valid_i;
  logic [5:0] enq_handle_i;
  logic [4:0] enq_port_i;
  logic [1:0] enq_class_i;
  logic [6:0] buf_used_i;
  logic       drop_valid_o;
  logic [5:0] drop_handle_o;
  logic       deq_req_i;
  logic [4:0] deq_port_i;
  logic       deq_valid_o;
  logic [5:0] deq_handle_o;
  logic [1:0] deq_class_o;

  int mq [NQ][$];
  int free_pool [$];
  int n_checks;
  int n_fail;
  bit done;

  txq_mgr u_txq_mgr (
    .clk          (clk),
    .rst_n        (rst_n),
    .enq_valid_i  (enq_valid_i),
    .enq_handle_i (enq_handle_i),
    .enq_port_i   (enq_port_i),
    .enq_class_i  (enq_class_i),
    .buf_used_i   (buf_used_i),
    .drop_valid_o (drop_valid_o),
    .drop_handle_o(drop_handle_o),
    .deq_req_i    (deq_req_i),
    .deq_port_i   (deq_port_i),
    .deq_valid_o  (deq_valid_o),
    .deq_handle_o (deq_handle_o),
    .deq_class_o  (deq_class_o)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive after posedge, compare at negedge, then advance the model
  task automatic cyc(bit ev, int ep, int ec, int used, bit dr, int dp, string dtag);
    int    h;
    bit    have;
    int    qi;
    int    dq;
    int    sel;
    bit    exp_drop;
    string t;
    string tq;
    h = 0;
    @(posedge clk);
    #1;
    have = ev && (free_pool.size() > 0);
    if (have) h = free_pool.pop_front();
    enq_valid_i  = have;
    enq_handle_i = 6'(h);
    enq_port_i   = 5'(ep);
    enq_class_i  = 2'(ec);
    buf_used_i   = 7'(used);
    deq_req_i    = dr;
    deq_port_i   = 5'(dp);
    @(negedge clk);
    qi       = ep * CLASSES + ec;
    exp_drop = have && ((used > GLIM) || (mq[qi].size() >= QLIM));
    if (!have)                     t = "R10";
    else if (used > GLIM)          t = "R3";
    else if (mq[qi].size() >= QLIM) t = "R4";
    else                           t = "R2";
    check(t, "drop_valid", int'(drop_valid_o), int'(exp_drop));
    if (exp_drop) check(t, "drop_handle", int'(drop_handle_o), h);
    sel = -1;
    for (int c = CLASSES - 1; c >= 0; c--) begin
      if ((sel < 0) && (mq[dp * CLASSES + c].size() > 0)) sel = c;
    end
    if (dr) begin
      tq = (dtag != "") ? dtag : ((sel < 0) ? "R6" : "R5");
      check(tq, "deq_valid", int'(deq_valid_o), int'(sel >= 0));
      if (sel >= 0) begin
        dq = dp * CLASSES + sel;
        check(tq, "deq_class", int'(deq_class_o), sel);
        check((dtag != "") ? dtag : "R7", "deq_handle", int'(deq_handle_o), mq[dq][0]);
        free_pool.push_back(mq[dq].pop_front());
      end
    end else begin
      check("R6", "deq_valid without request", int'(deq_valid_o), 0);
    end
    if (have) begin
      if (exp_drop) free_pool.push_back(h);
      else          mq[qi].push_back(h);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n        = 1'b0;
    enq_valid_i  = 1'b0;
    enq_handle_i = '0;
    enq_port_i   = '0;
    enq_class_i  = '0;
    buf_used_i   = '0;
    deq_req_i    = 1'b0;
    deq_port_i   = '0;
    for (int i = 0; i < HANDLES; i++) free_pool.push_back(i);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: every port idle after reset
    for (int p = 0; p < PORTS; p++) cyc(0, 0, 0, 0, 1, p, "R1");

    // R7: FIFO order inside one class
    for (int i = 0; i < 3; i++) cyc(1, 2, 1, 10, 0, 0, "");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 2, "R7");
    cyc(0, 0, 0, 0, 1, 2, "R6");

    // R5: strict priority and empty-class skip
    cyc(1, 5, 0, 5, 0, 0, "");
    cyc(1, 5, 2, 5, 0, 0, "");
    cyc(1, 5, 3, 5, 0, 0, "");
    cyc(1, 5, 1, 5, 0, 0, "");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 5, "R5");

    // R4: per-queue limit, plus R6 on an untouched port
    for (int i = 0; i < QLIM + 2; i++) cyc(1, 7, 0, 20, 0, 0, "");
    cyc(0, 0, 0, 0, 1, 9, "R6");
    for (int i = 0; i < QLIM + 1; i++) cyc(0, 0, 0, 0, 1, 7, "R4");

    // R3: global threshold boundary
    cyc(1, 3, 2, GLIM + 1, 0, 0, "");
    cyc(1, 3, 2, 63, 0, 0, "");
    cyc(1, 3, 2, GLIM, 0, 0, "");
    cyc(0, 0, 0, 0, 1, 3, "R3");
    cyc(0, 0, 0, 0, 1, 3, "R3");

    // R8: single-entry dequeue with same-cycle enqueue to the same queue
    cyc(1, 10, 2, 0, 0, 0, "");
    cyc(1, 10, 2, 0, 1, 10, "R8");
    cyc(0, 0, 0, 0, 1, 10, "R8");
    cyc(0, 0, 0, 0, 1, 10, "R8");
    cyc(1, 11, 1, 0, 1, 11, "R8");
    cyc(0, 0, 0, 0, 1, 11, "R8");

    // R10: no drop without an offer, even under global pressure
    for (int i = 0; i < 4; i++) cyc(0, 4, 1, 63, 1, 4, "");

    // R9: mixed traffic across all ports
    for (int i = 0; i < 3000; i++) begin
      int ep;
      int used;
      ep   = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, PORTS - 1));
      used = ($urandom_range(0, 9) == 0) ? int'($urandom_range(GLIM + 1, 63)) : int'($urandom_range(0, GLIM));
      cyc($urandom_range(0, 9) < 6, ep, int'($urandom_range(0, 3)), used,
          $urandom_range(0, 9) < 6, int'($urandom_range(0, 7)), "R9");
    end
    for (int p = 0; p < PORTS; p++) begin
      for (int i = 0; i < QLIM * CLASSES + 1; i++) cyc(0, 0, 0, 0, 1, p, "R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL ALL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule